// File: doc/BRIEF.md
# Highlight-Safe Dummy Clamp Controller

This controller sits in the digital part of an image-sensor front end and decides which reference the black-level clamp follows on each line. It captures two converted levels once per line: the optical-black level, taken while `ob_win` is high, and the dummy-pixel level, taken while `dm_win` is high. A very bright scene can leak light into the optical-black pixels. When the optical-black level then rises above the dummy level by more than a programmable margin, the controller moves the clamp onto the dummy level. While the dummy clamp is in use, it also supplies a reduced feedback-current code for the analog current cell.

The controller also produces a dummy-clamp timing strobe. The strobe follows the rising edge of the blanking input after a programmable number of pixel clocks and lasts a fixed number of clocks. Software writes a 5-bit clamp field (margin code and current code) and an 8-bit strobe offset. Neither write takes effect until the next line boundary, which is the rising edge of `blank`. A margin code of zero switches the feature off.

Top module: `hl_clamp_ctrl`

## Requirements
- R1: At the end of each optical-black window, `clamp_dmy` becomes 1 if the optical-black level is strictly greater than the dummy level plus 128 times the margin code. Otherwise it becomes 0. The sum is formed on 13 bits, so a dummy level near full scale cannot wrap around.
- R2: When the active margin code is 0, the end of an optical-black window always sets `clamp_dmy` to 0, whatever the captured levels are.
- R3: `fb_div` gives the base-2 logarithm of the current divisor. It is 0 (full current) while `clamp_dmy` is 0. While `clamp_dmy` is 1, it equals the current code plus 2: code 0 gives 2 (1/4), code 1 gives 3 (1/8), code 2 gives 4 (1/16) and code 3 gives 5 (1/32).
- R4: `clamp_dmy` and `fb_div` change only on the clock edge that follows the falling edge of `ob_win`. New dummy samples or other activity in between leave them unchanged.
- R5: Each captured level is the last `pix_data` sample taken while its window strobe was high.
- R6: `cfg_wdata[2:0]` is the margin code and `cfg_wdata[4:3]` is the current code. A value written with `cfg_we` becomes active only at the next rising edge of `blank`. A write made in the middle of a line has no effect on that line's decision.
- R7: Call the first clock edge at which `blank` is seen high edge 0, and let D be the active offset. `dmy_pulse` is high after edges D through D+PW-1 (PW = 4 by default) and low otherwise.
- R8: An offset written with `dly_we` takes effect at the next rising edge of `blank`. A write made while a strobe sequence is running does not move that strobe.
- R9: While reset is held and after it is released, `clamp_dmy`, `fb_div` and `dmy_pulse` are 0 until the first line activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blank | input | 1 | Blanking pulse; its rising edge marks a line boundary |
| ob_win | input | 1 | Optical-black capture window |
| dm_win | input | 1 | Dummy-pixel capture window |
| pix_data | input | 12 | Converted pixel code |
| cfg_we | input | 1 | Write strobe for the clamp field |
| cfg_wdata | input | 5 | [2:0] margin code, [4:3] current code |
| dly_we | input | 1 | Write strobe for the strobe offset |
| dly_wdata | input | 8 | Strobe offset in pixel clocks |
| clamp_dmy | output | 1 | 1 selects dummy-level clamping |
| fb_div | output | 3 | Log2 of the feedback-current divisor |
| dmy_pulse | output | 1 | Dummy-clamp timing strobe |

## Verification
The line boundary loads two things in the same cycle: the clamp field that has been waiting, and a new strobe sequence. A configuration write can also arrive in the middle of a line, in the same stretch where the decision is being formed. The bench provokes this overlap by writing a margin code of 0 after `blank` has risen. It then expects the decision at the end of the optical-black window to still follow the old margin, and expects the new margin to govern only the following line. The same overlap is checked for the strobe: an offset written while a strobe is running must leave that strobe's position unchanged and must move the strobe on the next line.

// File: rtl/hlc_pkg.sv
package hlc_pkg;
  localparam int THR_W = 3;
  localparam int CUR_W = 2;

  typedef struct packed {
    logic [CUR_W-1:0] cur;
    logic [THR_W-1:0] thr;
  } clamp_cfg_t;
endpackage

// File: rtl/hlc_level_cap.sv
module hlc_level_cap #(
  parameter int DW  = 12,
  parameter int AVG = 0
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          win_i,
  input  logic [DW-1:0] pix_i,
  output logic [DW-1:0] lvl_o
);
  if (AVG == 0) begin : g_last
    logic [DW-1:0] lvl_q, lvl_d;
    always_comb lvl_d = win_i ? pix_i : lvl_q;
    always_ff @(posedge clk or negedge rst_ni)
      if (!rst_ni) lvl_q <= '0;
      else         lvl_q <= lvl_d;
    assign lvl_o = lvl_q;
  end else begin : g_avg
    logic [3:0][DW-1:0] hist_q, hist_d;
    logic [DW+1:0]      sum;
    always_comb begin
      hist_d = hist_q;
      if (win_i) hist_d = {hist_q[2:0], pix_i};
    end
    always_ff @(posedge clk or negedge rst_ni)
      if (!rst_ni) hist_q <= '0;
      else         hist_q <= hist_d;
    always_comb sum = (DW+2)'(hist_q[0]) + (DW+2)'(hist_q[1])
                    + (DW+2)'(hist_q[2]) + (DW+2)'(hist_q[3]);
    assign lvl_o = sum[DW+1:2];
  end

  // R5
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !win_i |=> $stable(lvl_o));
endmodule

// File: rtl/hlc_decide.sv
module hlc_decide
  import hlc_pkg::*;
#(
  parameter int DW      = 12,
  parameter int STEP_SH = 7
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          bnd_i,
  input  logic          cfg_we_i,
  input  clamp_cfg_t    cfg_i,
  input  logic          ob_win_i,
  input  logic [DW-1:0] ob_lvl_i,
  input  logic [DW-1:0] dm_lvl_i,
  output logic          sel_o,
  output logic [2:0]    div_o
);
  localparam int SW = DW + 1;

  clamp_cfg_t    pend_q, pend_d, act_q, act_d;
  logic          obw_q, end_ob, hit;
  logic          sel_q, sel_d;
  logic [2:0]    div_q, div_d;
  logic [SW-1:0] ref_sum;

  assign end_ob  = obw_q & ~ob_win_i;
  assign ref_sum = SW'(dm_lvl_i) + (SW'(act_q.thr) << STEP_SH);
  assign hit     = (act_q.thr != '0) && (SW'(ob_lvl_i) > ref_sum);

  always_comb begin
    pend_d = cfg_we_i ? cfg_i : pend_q;
    act_d  = bnd_i ? pend_q : act_q;
    sel_d  = sel_q;
    div_d  = div_q;
    if (end_ob) begin
      sel_d = hit;
      div_d = hit ? 3'(act_q.cur) + 3'd2 : 3'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni)
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
      obw_q  <= 1'b0;
      sel_q  <= 1'b0;
      div_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
      obw_q  <= ob_win_i;
      sel_q  <= sel_d;
      div_q  <= div_d;
    end

  assign sel_o = sel_q;
  assign div_o = div_q;

  // R2
  thr_off_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (end_ob && act_q.thr == '0) |=> !sel_q);
  // R4
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !end_ob |=> ($stable(sel_q) && $stable(div_q)));
  // R3
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    sel_q |-> (div_q >= 3'd2 && div_q <= 3'd5));
  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !bnd_i |=> $stable(act_q));
endmodule

// File: rtl/hlc_pulse_gen.sv
module hlc_pulse_gen #(
  parameter int DLY_W = 8,
  parameter int PW    = 4
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             blank_i,
  input  logic             dly_we_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             bnd_o,
  output logic             pulse_o
);
  localparam int PH_W = DLY_W + 2;

  logic             blank_q, run_q, run_d;
  logic [PH_W-1:0]  ph_q, ph_d, p_end, p_last;
  logic [DLY_W-1:0] pend_q, pend_d, act_q, act_d;

  assign bnd_o  = blank_i & ~blank_q;
  assign p_end  = PH_W'(act_q) + PH_W'(PW);
  assign p_last = p_end - PH_W'(1);

  always_comb begin
    pend_d = dly_we_i ? dly_i : pend_q;
    act_d  = act_q;
    run_d  = run_q;
    ph_d   = ph_q;
    if (bnd_o) begin
      act_d = pend_q;
      run_d = 1'b1;
      ph_d  = '0;
    end else if (run_q) begin
      ph_d = ph_q + PH_W'(1);
      if (ph_q == p_last) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni)
    if (!rst_ni) begin
      blank_q <= 1'b0;
      run_q   <= 1'b0;
      ph_q    <= '0;
      pend_q  <= '0;
      act_q   <= '0;
    end else begin
      blank_q <= blank_i;
      run_q   <= run_d;
      ph_q    <= ph_d;
      pend_q  <= pend_d;
      act_q   <= act_d;
    end

  assign pulse_o = run_q && (ph_q >= PH_W'(act_q)) && (ph_q < p_end);

  // R7
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(pulse_o) |-> (ph_q == PH_W'(act_q)));
  // R8
  dly_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !bnd_o |=> $stable(act_q));
endmodule

// File: rtl/hl_clamp_ctrl.sv
module hl_clamp_ctrl
  import hlc_pkg::*;
#(
  parameter int DW    = 12,
  parameter int DLY_W = 8,
  parameter int PW    = 4,
  parameter int AVG   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blank,
  input  logic             ob_win,
  input  logic             dm_win,
  input  logic [DW-1:0]    pix_data,
  input  logic             cfg_we,
  input  logic [4:0]       cfg_wdata,
  input  logic             dly_we,
  input  logic [DLY_W-1:0] dly_wdata,
  output logic             clamp_dmy,
  output logic [2:0]       fb_div,
  output logic             dmy_pulse
);
  logic [1:0]    rst_sync_q;
  logic          rst_i, bnd;
  logic [DW-1:0] ob_lvl, dm_lvl;
  clamp_cfg_t    cfg_w;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  assign rst_i = rst_sync_q[1];

  assign cfg_w = clamp_cfg_t'(cfg_wdata);

  hlc_level_cap #(.DW(DW), .AVG(AVG)) u_ob_cap (
    .clk(clk), .rst_ni(rst_i), .win_i(ob_win), .pix_i(pix_data), .lvl_o(ob_lvl));

  hlc_level_cap #(.DW(DW), .AVG(AVG)) u_dm_cap (
    .clk(clk), .rst_ni(rst_i), .win_i(dm_win), .pix_i(pix_data), .lvl_o(dm_lvl));

  hlc_pulse_gen #(.DLY_W(DLY_W), .PW(PW)) u_pulse (
    .clk(clk), .rst_ni(rst_i), .blank_i(blank), .dly_we_i(dly_we),
    .dly_i(dly_wdata), .bnd_o(bnd), .pulse_o(dmy_pulse));

  hlc_decide #(.DW(DW)) u_decide (
    .clk(clk), .rst_ni(rst_i), .bnd_i(bnd), .cfg_we_i(cfg_we), .cfg_i(cfg_w),
    .ob_win_i(ob_win), .ob_lvl_i(ob_lvl), .dm_lvl_i(dm_lvl),
    .sel_o(clamp_dmy), .div_o(fb_div));
endmodule

// File: tb/hl_clamp_ctrl_tb.sv
module hl_clamp_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n, blank, ob_win, dm_win, cfg_we, dly_we;
  logic [11:0] pix_data;
  logic [4:0]  cfg_wdata;
  logic [7:0]  dly_wdata;
  logic        clamp_dmy, dmy_pulse;
  logic [2:0]  fb_div;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hl_clamp_ctrl u_dut (.*);

  // {thr, cur, ob, dm, exp_sel, exp_div}
  localparam logic [32:0] VEC [8] = '{
    {3'd1, 2'd0, 12'd400,  12'd200,  1'b1, 3'd2},
    {3'd1, 2'd1, 12'd328,  12'd200,  1'b0, 3'd0},
    {3'd1, 2'd1, 12'd329,  12'd200,  1'b1, 3'd3},
    {3'd7, 2'd3, 12'd4095, 12'd3200, 1'b0, 3'd0},
    {3'd7, 2'd3, 12'd4095, 12'd3198, 1'b1, 3'd5},
    {3'd0, 2'd2, 12'd4095, 12'd0,    1'b0, 3'd0},
    {3'd4, 2'd2, 12'd1000, 12'd400,  1'b1, 3'd4},
    {3'd3, 2'd0, 12'd100,  12'd500,  1'b0, 3'd0}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic line(bit pre_we, logic [4:0] pre_w, bit mid_we, logic [4:0] mid_w,
                      logic [11:0] ob, logic [11:0] dm);
    @(negedge clk); cfg_we = pre_we; cfg_wdata = pre_w;
    @(negedge clk); cfg_we = 0; blank = 1;
    @(negedge clk);
    @(negedge clk); blank = 0; cfg_we = mid_we; cfg_wdata = mid_w;
    dm_win = 1; pix_data = dm ^ 12'h555;
    @(negedge clk); cfg_we = 0; pix_data = dm;
    @(negedge clk); dm_win = 0; ob_win = 1; pix_data = ~ob;
    @(negedge clk); pix_data = ob;
    @(negedge clk); ob_win = 0; pix_data = 12'habc;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; blank = 0; ob_win = 0; dm_win = 0; cfg_we = 0; dly_we = 0;
    pix_data = 0; cfg_wdata = 0; dly_wdata = 0;
    repeat (3) @(negedge clk);
    chk("R9 sel in reset", clamp_dmy, 0);
    chk("R9 div in reset", fb_div, 0);
    chk("R9 pulse in reset", dmy_pulse, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R9 sel after reset", clamp_dmy, 0);

    // R1 R3 R5 table walk
    foreach (VEC[i]) begin
      line(1, {VEC[i][29:28], VEC[i][32:30]}, 0, 5'd0, VEC[i][27:16], VEC[i][15:4]);
      chk($sformatf("R1 sel vec%0d", i), clamp_dmy, VEC[i][3]);
      chk($sformatf("R3 div vec%0d", i), fb_div, VEC[i][2:0]);
    end

    // R2 R6: mid-line write of margin 0 is deferred
    line(1, {2'd0, 3'd1}, 0, 5'd0, 12'd400, 12'd200);
    chk("R1 setup sel", clamp_dmy, 1);
    line(0, 5'd0, 1, {2'd1, 3'd0}, 12'd400, 12'd200);
    chk("R6 mid-line write ignored sel", clamp_dmy, 1);
    chk("R6 mid-line write ignored div", fb_div, 2);
    line(0, 5'd0, 0, 5'd0, 12'd400, 12'd200);
    chk("R2 margin 0 forces ob clamp", clamp_dmy, 0);
    chk("R2 div zero", fb_div, 0);

    // R4 hold between windows
    line(1, {2'd3, 3'd2}, 0, 5'd0, 12'd1000, 12'd100);
    chk("R4 setup sel", clamp_dmy, 1);
    @(negedge clk); dm_win = 1; pix_data = 12'd4000;
    @(negedge clk); dm_win = 0; ob_win = 1; pix_data = 12'd10;
    @(negedge clk);
    chk("R4 sel held mid-line", clamp_dmy, 1);
    chk("R4 div held mid-line", fb_div, 5);
    ob_win = 0;
    @(posedge clk); @(negedge clk);
    chk("R4 sel updated at ob end", clamp_dmy, 0);

    // R7 R8 strobe timing
    dly_we = 1; dly_wdata = 8'd3;
    @(negedge clk); dly_we = 0;
    @(negedge clk); blank = 1;
    for (int j = 0; j < 9; j++) begin
      @(posedge clk); @(negedge clk);
      chk($sformatf("R7 pulse D3 j%0d", j), dmy_pulse, (j >= 3 && j < 7));
      if (j == 1) begin dly_we = 1; dly_wdata = 8'd0; end
      if (j == 2) dly_we = 0;
    end
    blank = 0;
    @(negedge clk); blank = 1;
    for (int j = 0; j < 6; j++) begin
      @(posedge clk); @(negedge clk);
      chk($sformatf("R8 pulse D0 j%0d", j), dmy_pulse, (j < 4));
    end
    blank = 0;
    @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule